// File: doc/BRIEF.md
# I/O Port Space Decoder with Legacy Display and Expansion-Bus Aliasing

This block steers an I/O port access to one of several downstream destinations. It holds four programmable window pairs. Each pair has a base register and a limit register. An incoming request carries a port address and a read/write flag. One clock later the decoder reports whether any window claimed the request. On a hit it also reports the destination node, the destination link and the index of the winning pair.

Two legacy rules sit on top of the plain 4 KB-granular range compare, and both apply only below 64 KB. First, a pair can claim the classic display-adapter ports wherever the low ten address bits alias onto them, whatever its base and limit say. Second, a pair can refuse the range match for the upper three quarters of every 1 KB block, which keeps old expansion-bus aliases away from it. Software programs the pairs through a simple register write port and can read them back through a combinational read port.

Top module: `io_space_decoder`

## Requirements
- R1: After reset every base and limit register reads zero, and no request hits.
- R2: The base register keeps read-enable in bit 0, write-enable in bit 1, display-alias enable in bit 4, bus-alias filter enable in bit 5 and window start page (address bits 24:12) in bits 24:12. The limit register keeps destination node in bits 2:0, destination link in bits 5:4 and window end page in bits 24:12. Every other bit reads zero.
- R3: A limit write whose link field is 2'b11 (reserved) updates the node and page but leaves the stored link unchanged. A stored link never holds 2'b11.
- R4: A pair's range matches when start page <= address[24:12] <= end page, with both bounds inclusive.
- R5: A read request can hit a pair only when its read-enable is set. A write request can hit a pair only when its write-enable is set. This applies to range and display matches alike.
- R6: With the display-alias enable set, an address below 0x10000 whose bits 9:0 lie in 0x3B0–0x3BB or 0x3C0–0x3DF matches regardless of the pair's pages. Addresses at or above 0x10000 never match this way.
- R7: With the bus-alias filter set, an address below 0x10000 whose bits 9:8 are not 00 cannot match that pair's range. At or above 0x10000 the filter has no effect.
- R8: A display-alias match takes precedence over the bus-alias filter on the same pair.
- R9: When several pairs match, the lowest-numbered pair wins. Its node, link and index appear on the outputs.
- R10: On a miss, or in a cycle with no valid request, the next cycle shows hit = 0 and node, link and pair = 0.
- R11: The result appears exactly one cycle after the request. It is decoded with the register contents from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_pair | input | 2 | Pair index for the write |
| cfg_limit | input | 1 | Write target: 1 = limit register, 0 = base register |
| cfg_wdata | input | 32 | Write data |
| cfg_rpair | input | 2 | Pair index for the readback |
| cfg_rlimit | input | 1 | Readback source: 1 = limit register, 0 = base register |
| cfg_rdata | output | 32 | Readback data (combinational) |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request type: 1 = write, 0 = read |
| req_addr | input | 25 | I/O port address |
| out_hit | output | 1 | Request of the previous cycle was claimed |
| out_node | output | 3 | Destination node of the winner |
| out_link | output | 2 | Destination link of the winner |
| out_pair | output | 2 | Index of the winning pair |

## Verification
Directed addresses probe both edges of each range and each edge of the two display-port aliases. They also probe aliases at 0x13B4 and 0x103B0, which separate a compare on the low ten bits from a full compare and show the 64 KB cut-off. Offsets 0x050, 0x150, 0x450 and 0x750 check the filter both inside and outside the first quarter of a 1 KB block, on each side of 64 KB. Overlapping windows and a write landing in the same cycle as a request show the priority and the timing of register updates. A long stretch of random programming and addresses is then compared every cycle against a behavioural model that uses integer division and modulo arithmetic.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
  localparam int IO_AW    = 25;             // I/O port address width
  localparam int PAGE_LSB = 12;             // 4 KB window granularity
  localparam int PAGE_W   = IO_AW - PAGE_LSB;
  localparam int NODE_W   = 3;
  localparam int LINK_W   = 2;
  localparam int REG_W    = 32;
  localparam logic [LINK_W-1:0] LINK_RSVD = 2'b11;
  localparam logic [REG_W-1:0] BASE_MASK  = 32'h01FF_F033;
  localparam logic [REG_W-1:0] LIMIT_MASK = 32'h01FF_F037;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic              bus_filt;
    logic              disp_en;
    logic              wr_ok;
    logic              rd_ok;
  } win_base_t;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [LINK_W-1:0] link;
    logic [NODE_W-1:0] node;
  } win_limit_t;

  // True when the address lies in the first 64 KB of port space.
  function automatic logic below_64k(input logic [IO_AW-1:0] a);
    return a[IO_AW-1:16] == '0;
  endfunction

  // Low ten bits alias onto one of the legacy display port groups.
  function automatic logic disp_alias(input logic [9:0] off);
    return ((off >= 10'h3B0) && (off <= 10'h3BB)) ||
           ((off >= 10'h3C0) && (off <= 10'h3DF));
  endfunction

  // Offset lies in the upper 768 bytes of its 1 KB block.
  function automatic logic bus_alias(input logic [9:0] off);
    return off[9:8] != 2'b00;
  endfunction

  function automatic logic page_inside(input logic [PAGE_W-1:0] pg,
                                       input logic [PAGE_W-1:0] lo,
                                       input logic [PAGE_W-1:0] hi);
    return (pg >= lo) && (pg <= hi);
  endfunction

  function automatic logic [REG_W-1:0] pack_base(input win_base_t b);
    logic [REG_W-1:0] r;
    r = '0;
    r[0] = b.rd_ok;
    r[1] = b.wr_ok;
    r[4] = b.disp_en;
    r[5] = b.bus_filt;
    r[IO_AW-1:PAGE_LSB] = b.page;
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_limit(input win_limit_t l);
    logic [REG_W-1:0] r;
    r = '0;
    r[NODE_W-1:0] = l.node;
    r[5:4] = l.link;
    r[IO_AW-1:PAGE_LSB] = l.page;
    return r;
  endfunction
endpackage

// File: rtl/iodec_regs.sv
module iodec_regs
  import iodec_pkg::*;
#(
  parameter int NPAIR = 4,
  localparam int PW = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_pair,
  input  logic             wr_limit,
  input  logic [REG_W-1:0] wr_data,
  input  logic [PW-1:0]    rd_pair,
  input  logic             rd_limit,
  output logic [REG_W-1:0] rd_data,
  output win_base_t        base_q  [NPAIR],
  output win_limit_t       limit_q [NPAIR]
);
  logic [LINK_W-1:0] wr_link;
  logic              link_is_rsvd;
  logic              unused_rsvd_bits;

  assign wr_link          = wr_data[5:4];
  assign link_is_rsvd     = (wr_link == LINK_RSVD);
  assign unused_rsvd_bits = ^{wr_data[REG_W-1:IO_AW], wr_data[11:6], wr_data[3]};

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic sel_base, sel_limit;
    assign sel_base  = wr_en && (wr_pair == PW'(p)) && !wr_limit;
    assign sel_limit = wr_en && (wr_pair == PW'(p)) &&  wr_limit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[p]  <= '0;
        limit_q[p] <= '0;
      end else begin
        if (sel_base) begin
          base_q[p].rd_ok    <= wr_data[0];
          base_q[p].wr_ok    <= wr_data[1];
          base_q[p].disp_en  <= wr_data[4];
          base_q[p].bus_filt <= wr_data[5];
          base_q[p].page     <= wr_data[IO_AW-1:PAGE_LSB];
        end
        if (sel_limit) begin
          limit_q[p].node <= wr_data[NODE_W-1:0];
          limit_q[p].page <= wr_data[IO_AW-1:PAGE_LSB];
          if (!link_is_rsvd) limit_q[p].link <= wr_link;
        end
      end
    end

    AST_LINK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      sel_limit && link_is_rsvd |=> $stable(limit_q[p].link)); // R3
    AST_LINK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      limit_q[p].link != LINK_RSVD); // R3
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_pair) < NPAIR) begin
      rd_data = rd_limit ? pack_limit(limit_q[rd_pair]) : pack_base(base_q[rd_pair]);
    end
  end
endmodule

// File: rtl/iodec_match.sv
module iodec_match
  import iodec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  win_base_t        base,
  input  win_limit_t       limit,
  input  logic [IO_AW-1:0] addr,
  input  logic             is_write,
  output logic             hit,
  output logic             disp_hit,
  output logic             range_hit,
  output logic             filt_block
);
  logic       low;
  logic       type_ok;
  logic [9:0] off;

  assign off        = addr[9:0];
  assign low        = below_64k(addr);
  assign type_ok    = is_write ? base.wr_ok : base.rd_ok;
  assign disp_hit   = base.disp_en && low && disp_alias(off);
  assign range_hit  = page_inside(addr[IO_AW-1:PAGE_LSB], base.page, limit.page);
  assign filt_block = base.bus_filt && low && bus_alias(off);
  assign hit        = type_ok && (disp_hit || (range_hit && !filt_block));

  AST_DISP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    disp_hit |-> addr < IO_AW'(32'h10000)); // R6
  AST_FILT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    filt_block && !disp_hit |-> !hit); // R7
  AST_DISP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    disp_hit && type_ok |-> hit); // R8
  AST_TYPE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (is_write ? base.wr_ok : base.rd_ok)); // R5
endmodule

// File: rtl/iodec_pick.sv
module iodec_pick #(
  parameter int NPAIR = 4,
  localparam int PW = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] hit_vec,
  output logic [NPAIR-1:0] win,
  output logic [PW-1:0]    win_idx,
  output logic             any
);
  assign any = |hit_vec;
  assign win = hit_vec & (~hit_vec + NPAIR'(1));

  always_comb begin
    win_idx = '0;
    for (int i = NPAIR - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = PW'(i);
    end
  end

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win)); // R9
  AST_WIN_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> win[win_idx]); // R9

  for (genvar i = 0; i < NPAIR; i++) begin : g_low
    localparam logic [NPAIR-1:0] BELOW = NPAIR'((1 << i) - 1);
    AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      win[i] |-> (hit_vec & BELOW) == '0); // R9
  end
endmodule

// File: rtl/io_space_decoder.sv
module io_space_decoder
  import iodec_pkg::*;
#(
  parameter int NPAIR = 4,
  localparam int PW = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [PW-1:0]    cfg_pair,
  input  logic             cfg_limit,
  input  logic [31:0]      cfg_wdata,
  input  logic [PW-1:0]    cfg_rpair,
  input  logic             cfg_rlimit,
  output logic [31:0]      cfg_rdata,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IO_AW-1:0] req_addr,
  output logic             out_hit,
  output logic [NODE_W-1:0] out_node,
  output logic [LINK_W-1:0] out_link,
  output logic [PW-1:0]    out_pair
);
  win_base_t  base_q  [NPAIR];
  win_limit_t limit_q [NPAIR];
  logic [NPAIR-1:0] hit_vec, disp_vec, range_vec, filt_vec, win_vec;
  logic [PW-1:0]    win_idx;
  logic             any_hit;
  logic             take;

  iodec_regs #(.NPAIR(NPAIR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_pair(cfg_pair), .wr_limit(cfg_limit), .wr_data(cfg_wdata),
    .rd_pair(cfg_rpair), .rd_limit(cfg_rlimit), .rd_data(cfg_rdata),
    .base_q(base_q), .limit_q(limit_q)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_match
    iodec_match u_match (
      .clk(clk), .rst_n(rst_n),
      .base(base_q[p]), .limit(limit_q[p]),
      .addr(req_addr), .is_write(req_write),
      .hit(hit_vec[p]), .disp_hit(disp_vec[p]),
      .range_hit(range_vec[p]), .filt_block(filt_vec[p])
    );
  end

  iodec_pick #(.NPAIR(NPAIR)) u_pick (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec),
    .win(win_vec), .win_idx(win_idx), .any(any_hit)
  );

  assign take = req_valid && any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hit  <= 1'b0;
      out_node <= '0;
      out_link <= '0;
      out_pair <= '0;
    end else begin
      out_hit  <= take;
      out_node <= take ? limit_q[win_idx].node : '0;
      out_link <= take ? limit_q[win_idx].link : '0;
      out_pair <= take ? win_idx : '0;
    end
  end

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hit |-> (out_node == '0 && out_link == '0 && out_pair == '0)); // R10
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_hit); // R10
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_hit); // R11
  AST_OUT_LINK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_link != LINK_RSVD); // R3
endmodule

// File: tb/test_io_space_decoder.sv
module test_io_space_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_limit = 1'b0, cfg_rlimit = 1'b0;
  logic [1:0]  cfg_pair = '0, cfg_rpair = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [24:0] req_addr = '0;
  logic        out_hit;
  logic [2:0]  out_node;
  logic [1:0]  out_link;
  logic [1:0]  out_pair;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] base_m [4];
  logic [31:0] lim_m  [4];
  bit    exp_hit = 0;
  int    exp_node = 0, exp_link = 0, exp_pair = 0;
  string exp_tag = "R1";

  always #5 clk = ~clk;

  io_space_decoder i_io_space_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_pair(cfg_pair), .cfg_limit(cfg_limit), .cfg_wdata(cfg_wdata),
    .cfg_rpair(cfg_rpair), .cfg_rlimit(cfg_rlimit), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .out_hit(out_hit), .out_node(out_node), .out_link(out_link), .out_pair(out_pair)
  );

  // Behavioural reference: integer arithmetic on the whole address.
  task automatic ref_decode(input bit v, input bit wr, input int unsigned a,
                            output bit h, output int n, output int l, output int p);
    h = 0; n = 0; l = 0; p = 0;
    if (!v) return;
    for (int i = 0; i < 4; i++) begin
      int unsigned off, pg, lo, hi;
      bit en, low, disp, rng, filt;
      off  = a % 1024;
      pg   = a / 4096;
      lo   = (base_m[i] >> 12) & 32'h1FFF;
      hi   = (lim_m[i] >> 12) & 32'h1FFF;
      low  = a < 65536;
      en   = wr ? base_m[i][1] : base_m[i][0];
      disp = base_m[i][4] && low && ((off >= 944 && off <= 955) || (off >= 960 && off <= 991));
      rng  = (pg >= lo) && (pg <= hi);
      filt = base_m[i][5] && low && (off >= 256);
      if (en && (disp || (rng && !filt))) begin
        h = 1; n = lim_m[i] & 7; l = (lim_m[i] >> 4) & 3; p = i;
        return;
      end
    end
  endtask

  task automatic ref_write(input int sel, input bit lim, input logic [31:0] d);
    if (!lim) base_m[sel] = d & 32'h01FF_F033;
    else begin
      logic [31:0] nv;
      nv = d & 32'h01FF_F037;
      if (d[5:4] == 2'b11) nv[5:4] = lim_m[sel][5:4];
      lim_m[sel] = nv;
    end
  endtask

  task automatic compare();
    logic [31:0] exp_rd;
    vectors++;
    if (out_hit !== exp_hit || int'(out_node) != exp_node ||
        int'(out_link) != exp_link || int'(out_pair) != exp_pair) begin
      miscompares++;
      $display("FAIL %s decode: got hit=%0d node=%0d link=%0d pair=%0d, expected hit=%0d node=%0d link=%0d pair=%0d",
               exp_tag, out_hit, out_node, out_link, out_pair, exp_hit, exp_node, exp_link, exp_pair);
    end
    exp_rd = cfg_rlimit ? lim_m[cfg_rpair] : base_m[cfg_rpair];
    vectors++;
    if (cfg_rdata !== exp_rd) begin
      miscompares++;
      $display("FAIL %s readback pair %0d limit=%0d: got %h, expected %h",
               exp_tag, cfg_rpair, cfg_rlimit, cfg_rdata, exp_rd);
    end
  endtask

  task automatic step(input bit we, input int sel, input bit lim, input logic [31:0] wd,
                      input bit rv, input bit rw, input logic [24:0] a,
                      input int rsel, input bit rlim, input string tag);
    @(negedge clk);
    compare();
    cfg_we = we; cfg_pair = 2'(sel); cfg_limit = lim; cfg_wdata = wd;
    req_valid = rv; req_write = rw; req_addr = a;
    cfg_rpair = 2'(rsel); cfg_rlimit = rlim;
    ref_decode(rv, rw, a, exp_hit, exp_node, exp_link, exp_pair);
    exp_tag = tag;
    if (we) ref_write(sel, lim, wd);
  endtask

  // Shorthands: register write with readback of the same register; read or write request.
  task automatic wr(input int sel, input bit lim, input logic [31:0] d, input string tag);
    step(1, sel, lim, d, 0, 0, '0, sel, lim, tag);
  endtask
  task automatic rq(input bit rw, input logic [24:0] a, input string tag);
    step(0, 0, 0, '0, 1, rw, a, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin base_m[i] = '0; lim_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents and quiet outputs
    for (int i = 0; i < 8; i++) step(0, 0, 0, '0, 1, i[0], 25'(i * 4096), i / 2, i[0], "R1");

    // R2: field layout, reserved bits dropped
    wr(0, 0, 32'hFFFF_FFFF, "R2");
    wr(0, 1, 32'hFFFF_FFCF, "R2");
    wr(0, 0, 32'h0000_0000, "R2");
    // R3: reserved link code keeps the stored link
    wr(0, 1, 32'h0000_0010, "R3");
    wr(0, 1, 32'h0000_0035, "R3");
    step(0, 0, 0, '0, 0, 0, '0, 0, 1, "R3");

    // R4: inclusive page bounds (pair 1: pages 2..4)
    wr(1, 0, 32'h0000_2003, "R4");
    wr(1, 1, 32'h0000_4015, "R4");
    rq(0, 25'h01FFF, "R4"); rq(0, 25'h02000, "R4");
    rq(1, 25'h04FFF, "R4"); rq(0, 25'h05000, "R4");

    // R5: type enables
    wr(1, 0, 32'h0000_2001, "R5");
    rq(1, 25'h03000, "R5"); rq(0, 25'h03000, "R5");
    wr(1, 0, 32'h0000_2002, "R5");
    rq(1, 25'h03000, "R5"); rq(0, 25'h03000, "R5");
    wr(1, 0, 32'h0000_2001, "R5");

    // R6: display aliases on pair 2 (window far away)
    wr(2, 1, 32'h0010_0026, "R6");
    wr(2, 0, 32'h0010_0013, "R6");
    rq(0, 25'h003B0, "R6"); rq(0, 25'h003BB, "R6"); rq(0, 25'h003BC, "R6");
    rq(1, 25'h003C0, "R6"); rq(0, 25'h003DF, "R6"); rq(0, 25'h003E0, "R6");
    rq(0, 25'h013B4, "R6"); rq(0, 25'h103B0, "R6"); rq(0, 25'h003AF, "R6");

    // R7: bus-alias filter on pair 3 (pages 0..31)
    wr(3, 0, 32'h0000_0023, "R7");
    wr(3, 1, 32'h0001_F007, "R7");
    rq(0, 25'h00050, "R7"); rq(0, 25'h00150, "R7");
    rq(0, 25'h00450, "R7"); rq(0, 25'h00750, "R7");
    rq(0, 25'h10150, "R7"); rq(1, 25'h0FF50, "R7");

    // R8: display alias beats the filter; enables still gate it
    wr(2, 0, 32'h0000_0000, "R8");
    wr(3, 0, 32'h0000_0033, "R8");
    rq(0, 25'h003C0, "R8"); rq(1, 25'h003B4, "R8");
    wr(3, 0, 32'h0000_0031, "R8");
    rq(1, 25'h003C0, "R8"); rq(0, 25'h003C0, "R8");

    // R9: overlap, lowest index wins
    wr(0, 1, 32'h0000_3022, "R9");
    wr(0, 0, 32'h0000_2003, "R9");
    rq(0, 25'h03000, "R9"); rq(0, 25'h04000, "R9"); rq(0, 25'h02800, "R9");

    // R10: no request means no hit
    step(0, 0, 0, '0, 0, 0, 25'h03000, 0, 0, "R10");
    rq(0, 25'h1F000, "R10");

    // R11: same-cycle write does not affect that request; latency of one
    step(1, 0, 0, 32'h0, 1, 0, 25'h03000, 0, 0, "R11");
    rq(0, 25'h03000, "R11");

    // Random programming and traffic
    for (int k = 0; k < 3000; k++) begin
      bit we;
      we = ($urandom % 4) == 0;
      step(we, int'($urandom % 4), bit'($urandom % 2), $urandom & 32'h0000_F03F,
           bit'(($urandom % 8) != 0), bit'($urandom % 2), 25'($urandom % 32'h12000),
           int'($urandom % 4), bit'($urandom % 2), "R9");
    end

    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule